// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a small synchronous static RAM meant to sit behind a processor as a burst cache memory. The address, write data and clocked controls are captured on every rising clock edge into one input stage. The array is read from that stage, and the read word is captured in an output register. A read presented before edge N therefore appears after edge N+1. Writes are committed from the same input stage on the following edge, without any shaped write pulse.

An access starts when a strobe is asserted while `chip_sel` is high. There are two strobes: `cpu_start` for the processor side and `ctl_start` for the cache controller side. Both load the external address. While the access stays active, each later cycle continues it. A 2-bit counter over the two low address bits steps only in cycles with `step` high, in linear or interleaved order as selected by `burst_ilv`. Per-lane and global write enables choose which byte lanes a cycle writes. A cycle that writes no lane is a read. A strobe with `chip_sel` low deselects the part, and the data pins stop being driven one edge later. `out_en` and `sleep` are not clocked and gate the pin drive directly.

Top module: `burst_sync_sram`

## Requirements
- R1: A read presented before rising edge N drives `rd_oe` high and shows the addressed word on `rd_q` after edge N+1. Data words are LANES×LANE_W bits, and lane i is bits [i*LANE_W +: LANE_W].
- R2: A strobe (`cpu_start` or `ctl_start`) sampled with `chip_sel` high loads `addr_in` as the access address. When both strobes are high, the cycle follows the `cpu_start` rules.
- R3: In continuation cycles the burst count advances by one only when `step` is high. With `step` low, the same address is accessed again.
- R4: With `burst_ilv` low, the low two address bits are (start + count) mod 4. The upper address bits keep their loaded value, so the burst wraps within an aligned group of four.
- R5: With `burst_ilv` high, the low two address bits are the start low bits XOR the count (0,1,2,3).
- R6: Lane i is written when `wr_en` and `lane_en[i]` are both high. Lanes whose enable is low keep their contents.
- R7: All lanes are written when `wr_all` is high, or when `wr_en` is high with every `lane_en` bit set. During a write cycle `rd_oe` stays low.
- R8: In a cycle where `cpu_start` starts an access, the write controls are ignored and the cycle is a read.
- R9: A word written in one cycle is returned by a read of the same address presented in the very next cycle.
- R10: A strobe sampled with `chip_sel` low ends the access. `rd_oe` is low after the next edge, and later non-strobe cycles stay idle.
- R11: `out_en` low forces `rd_oe` low at once, without waiting for a clock edge. Restoring it shows the registered word again.
- R12: While `sleep` is high, `rd_oe` is low. Write controls presented while `sleep` is high leave the array unchanged.
- R13: After synchronous reset no access is active and `rd_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | AW = log2(DEPTH) | External word address |
| wdata | input | LANES*LANE_W | Write data |
| cpu_start | input | 1 | Processor-side access strobe (priority) |
| ctl_start | input | 1 | Controller-side access strobe |
| chip_sel | input | 1 | Select qualifier for strobes; low with a strobe deselects |
| step | input | 1 | Advance burst address in a continuation cycle |
| burst_ilv | input | 1 | Static order: 0 linear, 1 interleaved |
| wr_en | input | 1 | Write enable qualifying the lane enables |
| lane_en | input | LANES | Per-lane write enables |
| wr_all | input | 1 | Write every lane |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Unclocked low-power input |
| rd_q | output | LANES*LANE_W | Read data from the output register |
| rd_oe | output | 1 | Data pins driven when high, high impedance when low |

## Verification
The assertions assume that `sleep`, `burst_ilv` and the strobes are clean levels at each rising edge. They also assume that nothing is read from a word that has never been written, since the array has no reset. The bench changes every input only on the falling edge and holds `burst_ilv` steady inside each burst. Every read it issues targets addresses it has already written in full, and it switches `sleep` and `out_en` only between whole cycles.

// File: rtl/psb_pkg.sv
// Package: shared cycle type and burst address mixing for the burst SRAM.
// Assumes a four-word burst group on the two low address bits.
package psb_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_LOAD  = 2'd1,
        CYC_CONT  = 2'd2,
        CYC_DESEL = 2'd3
    } cyc_kind_e;

    // Low address bits for a given start value and burst count.
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input logic       ilv);
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/psb_addr_gen.sv
// Burst address generator: holds the loaded address and a 2-bit count,
// and returns the address for the current cycle combinationally.
// Assumes AW >= 3 and that load and adv are never high together.
module psb_addr_gen #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          ilv,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] cur_addr
);
    import psb_pkg::*;

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    cnt_next;

    // Next count: cleared on load, stepped on advance, held otherwise.
    always_comb begin
        if (load)
            cnt_next = 2'd0;
        else if (adv)
            cnt_next = cnt_q + 2'd1;
        else
            cnt_next = cnt_q;
    end

    // Address used by this cycle's access.
    always_comb begin
        if (load)
            cur_addr = ext_addr;
        else
            cur_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_next, ilv)};
    end

    // Burst state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else begin
            if (load)
                base_q <= ext_addr;
            cnt_q <= cnt_next;
        end
    end

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(cnt_q));

    assert_load_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (base_q == $past(ext_addr)));

endmodule

// File: rtl/psb_lane_decode.sv
// Byte-lane write decode: per-lane enable from the qualified lane bits or
// the global write, all forced off when the cycle may not write.
// Assumes suppress already covers strobe priority, sleep and idle cycles.
module psb_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             wr_en,
    input  logic [LANES-1:0] lane_en,
    input  logic             wr_all,
    input  logic             suppress,
    output logic [LANES-1:0] lane_wr
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One lane's write strobe.
        always_comb lane_wr[g] = !suppress && (wr_all || (wr_en && lane_en[g]));
    end
endmodule

// File: rtl/psb_array.sv
// Storage array split into one memory per byte lane so each lane has a
// single writer. Read is combinational. Contents are not reset.
module psb_array #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic [LANES-1:0] wr_lanes,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     rd_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_mem
        logic [LANE_W-1:0] mem [DEPTH];

        // Commit this lane's byte on its strobe.
        always_ff @(posedge clk) begin
            if (wr_lanes[g])
                mem[addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        // Lane read path.
        always_comb rd_data[g*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/burst_sync_sram.sv
// Pipelined burst synchronous SRAM top. Stage 1 registers the cycle's
// address, data, lane writes and read flag. The following edge commits the
// write or loads the output register. Deselect takes effect one edge
// after it is sampled.
// Assumes DEPTH is a power of two and at least 8.
module burst_sync_sram #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_in,
    input  logic [W-1:0]     wdata,
    input  logic             cpu_start,
    input  logic             ctl_start,
    input  logic             chip_sel,
    input  logic             step,
    input  logic             burst_ilv,
    input  logic             wr_en,
    input  logic [LANES-1:0] lane_en,
    input  logic             wr_all,
    input  logic             out_en,
    input  logic             sleep,
    output logic [W-1:0]     rd_q,
    output logic             rd_oe
);
    import psb_pkg::*;

    cyc_kind_e        kind;
    logic             active_q;
    logic             start_any;
    logic             load;
    logic             adv;
    logic             suppress;
    logic             is_rd;
    logic [LANES-1:0] lanes;
    logic [AW-1:0]    cur_addr;

    logic             st_rd;
    logic [LANES-1:0] st_lanes;
    logic [AW-1:0]    st_addr;
    logic [W-1:0]     st_wdata;
    logic [W-1:0]     arr_rd;
    logic             q_drive;
    logic [W-1:0]     q_reg;

    // Classify the cycle: strobe (load or deselect), continuation, or idle.
    always_comb begin
        start_any = cpu_start || ctl_start;
        if (start_any)
            kind = chip_sel ? CYC_LOAD : CYC_DESEL;
        else if (active_q)
            kind = CYC_CONT;
        else
            kind = CYC_IDLE;
        load     = (kind == CYC_LOAD);
        adv      = (kind == CYC_CONT) && step;
        suppress = cpu_start || sleep || (kind inside {CYC_IDLE, CYC_DESEL});
        is_rd    = (kind inside {CYC_LOAD, CYC_CONT}) && (lanes == '0);
    end

    psb_addr_gen #(.AW(AW)) i_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .ilv      (burst_ilv),
        .ext_addr (addr_in),
        .cur_addr (cur_addr)
    );

    psb_lane_decode #(.LANES(LANES)) i_dec (
        .wr_en    (wr_en),
        .lane_en  (lane_en),
        .wr_all   (wr_all),
        .suppress (suppress),
        .lane_wr  (lanes)
    );

    // Input stage: register the cycle's operation and keep the burst alive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            st_rd    <= 1'b0;
            st_lanes <= '0;
            st_addr  <= '0;
            st_wdata <= '0;
        end else begin
            active_q <= (kind == CYC_LOAD) || (kind == CYC_CONT);
            st_rd    <= is_rd;
            st_lanes <= lanes;
            st_addr  <= cur_addr;
            st_wdata <= wdata;
        end
    end

    psb_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) i_arr (
        .clk      (clk),
        .wr_lanes (st_lanes),
        .addr     (st_addr),
        .wr_data  (st_wdata),
        .rd_data  (arr_rd)
    );

    // Output register: capture read data and the drive flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_drive <= 1'b0;
            q_reg   <= '0;
        end else begin
            q_drive <= st_rd;
            if (st_rd)
                q_reg <= arr_rd;
        end
    end

    // Pin drive gated by the unclocked enables.
    always_comb begin
        rd_oe = q_drive && out_en && !sleep;
        rd_q  = q_reg;
    end

    assert_cpu_is_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start |=> (st_lanes == '0));

    assert_sleep_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (st_lanes == '0));

    assert_deselect_float_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_any && !chip_sel) |=> ##1 !q_drive);

    assert_read_pipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd |=> q_drive);

    assert_write_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_lanes != '0) |=> !q_drive);

endmodule

// File: tb/test_burst_sync_sram.sv
module test_burst_sync_sram;
    localparam int DEPTH  = 64;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int AW     = $clog2(DEPTH);
    localparam int W      = LANES * LANE_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    addr_in = '0;
    logic [W-1:0]     wdata = '0;
    logic             cpu_start = 1'b0, ctl_start = 1'b0, chip_sel = 1'b0, step = 1'b0;
    logic             burst_ilv = 1'b0, wr_en = 1'b0, wr_all = 1'b0;
    logic [LANES-1:0] lane_en = '0;
    logic             out_en = 1'b1, sleep = 1'b0;
    logic [W-1:0]     rd_q;
    logic             rd_oe;

    burst_sync_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) i_burst_sync_sram (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .wdata(wdata),
        .cpu_start(cpu_start), .ctl_start(ctl_start), .chip_sel(chip_sel),
        .step(step), .burst_ilv(burst_ilv), .wr_en(wr_en), .lane_en(lane_en),
        .wr_all(wr_all), .out_en(out_en), .sleep(sleep), .rd_q(rd_q), .rd_oe(rd_oe)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         due;
        logic       drv;
        logic [W-1:0] val;
        string      req;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Bench reference state
    logic [W-1:0]  bm [DEPTH];
    logic          m_act = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = 2'd0;

    // Driver: apply one cycle of inputs and push the predicted result
    task automatic cyc_op(input logic c, input logic k, input logic cs, input logic st,
                          input logic we, input logic [LANES-1:0] le, input logic all,
                          input logic [AW-1:0] a, input logic [W-1:0] d, input string req);
        logic             ld, ok, rd;
        logic [LANES-1:0] ln;
        logic [AW-1:0]    ea;
        exp_t             e;
        @(negedge clk);
        cpu_start = c; ctl_start = k; chip_sel = cs; step = st;
        wr_en = we; lane_en = le; wr_all = all; addr_in = a; wdata = d;
        ld = 1'b0; ok = 1'b0;
        if (c || k) begin
            if (cs) begin
                ld = 1'b1; ok = 1'b1; m_base = a; m_cnt = 2'd0; m_act = 1'b1;
            end else begin
                m_act = 1'b0;
            end
        end else if (m_act) begin
            ok = 1'b1;
            if (st) m_cnt = m_cnt + 2'd1;
        end
        if (ld)
            ea = a;
        else
            ea = {m_base[AW-1:2], burst_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
        ln = all ? '1 : (we ? le : '0);
        if (c || sleep || !ok) ln = '0;
        rd = ok && (ln == '0);
        e.due = cyc + 2;
        e.drv = rd;
        e.val = rd ? bm[ea] : '0;
        e.req = req;
        sb.push_back(e);
        for (int i = 0; i < LANES; i++)
            if (ln[i]) bm[ea][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
    endtask

    task automatic idle(input string req);
        cyc_op(0, 0, 0, 0, 0, '0, 0, '0, '0, req);
    endtask

    // Monitor: compare predicted results as the design produces them
    initial begin
        forever begin
            exp_t e;
            logic exp_oe;
            @(negedge clk);
            #5;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                e = sb.pop_front();
                exp_oe = e.drv && out_en && !sleep;
                n_chk++;
                if (rd_oe !== exp_oe) begin
                    n_bad++;
                    $display("FAIL %s: rd_oe actual %0b expected %0b (cycle %0d)", e.req, rd_oe, exp_oe, cyc);
                end else if (exp_oe && rd_q !== e.val) begin
                    n_bad++;
                    $display("FAIL %s: rd_q actual %h expected %h (cycle %0d)", e.req, rd_q, e.val, cyc);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        n_chk++;
        if (rd_oe !== 1'b0) begin
            n_bad++;
            $display("FAIL R13: rd_oe actual %0b expected 0 in reset", rd_oe);
        end
        rst_n = 1'b1;
        idle("R13"); idle("R13");

        // R7: global write burst 8..11, then all-lane write at 20
        cyc_op(0, 1, 1, 0, 0, '0, 1, 6'd8, 32'h1111_1111, "R7");
        cyc_op(0, 0, 0, 1, 0, '0, 1, '0, 32'h2222_2222, "R7");
        cyc_op(0, 0, 0, 1, 0, '0, 1, '0, 32'h3333_3333, "R7");
        cyc_op(0, 0, 0, 1, 0, '0, 1, '0, 32'h4444_4444, "R7");
        cyc_op(0, 1, 1, 0, 1, 4'b1111, 0, 6'd20, 32'hA5A5_5A5A, "R7");
        // R1/R4: linear read burst from 8
        cyc_op(1, 0, 1, 0, 0, '0, 0, 6'd8, '0, "R1");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R4");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R4");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R4");
        // R4: linear wrap from 10 via controller strobe
        cyc_op(0, 1, 1, 0, 0, '0, 0, 6'd10, '0, "R2");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R4");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R4");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R4");
        cyc_op(1, 0, 1, 0, 0, '0, 0, 6'd20, '0, "R7");
        // R5: interleaved from 9
        burst_ilv = 1'b1;
        cyc_op(1, 0, 1, 0, 0, '0, 0, 6'd9, '0, "R5");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R5");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R5");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R5");
        cyc_op(1, 0, 1, 0, 0, '0, 0, 6'd10, '0, "R5");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R5");
        burst_ilv = 1'b0;
        // R3: hold without step, then step
        cyc_op(1, 0, 1, 0, 0, '0, 0, 6'd8, '0, "R3");
        cyc_op(0, 0, 0, 0, 0, '0, 0, '0, '0, "R3");
        cyc_op(0, 0, 0, 0, 0, '0, 0, '0, '0, "R3");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R3");
        // R6/R9: lane write to 9, read next cycle
        cyc_op(0, 1, 1, 0, 1, 4'b0101, 0, 6'd9, 32'hAABB_CCDD, "R6");
        cyc_op(0, 1, 1, 0, 0, '0, 0, 6'd9, '0, "R9");
        cyc_op(0, 1, 1, 0, 1, 4'b1010, 0, 6'd9, 32'h0102_0304, "R6");
        cyc_op(0, 0, 0, 0, 0, '0, 0, '0, '0, "R9");
        // R8/R2: processor strobe with write controls, both strobes high
        cyc_op(1, 0, 1, 0, 0, '0, 1, 6'd10, 32'h0, "R8");
        cyc_op(1, 1, 1, 0, 1, 4'b1111, 1, 6'd11, 32'h0, "R2");
        cyc_op(0, 1, 1, 0, 0, '0, 0, 6'd10, '0, "R8");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R8");
        // R10: deselect ends the burst
        cyc_op(1, 0, 1, 0, 0, '0, 0, 6'd8, '0, "R10");
        cyc_op(1, 0, 0, 0, 0, '0, 0, 6'd8, '0, "R10");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R10");
        cyc_op(0, 0, 0, 1, 0, '0, 1, '0, 32'hDEAD_BEEF, "R10");
        cyc_op(0, 1, 0, 0, 0, '0, 0, 6'd9, '0, "R10");
        idle("R10");
        // R11: output enable low during a burst
        cyc_op(1, 0, 1, 0, 0, '0, 0, 6'd8, '0, "R11");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R11");
        out_en = 1'b0;
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R11");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R11");
        out_en = 1'b1;
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R11");
        idle("R11");
        // R12: sleep floats reads and blocks writes
        sleep = 1'b1;
        cyc_op(1, 0, 1, 0, 0, '0, 0, 6'd8, '0, "R12");
        cyc_op(0, 1, 1, 0, 0, '0, 1, 6'd11, 32'h5555_AAAA, "R12");
        cyc_op(0, 0, 0, 1, 1, 4'b0011, 0, '0, 32'h7777_7777, "R12");
        idle("R12");
        sleep = 1'b0;
        idle("R12");
        cyc_op(0, 1, 1, 0, 0, '0, 0, 6'd11, '0, "R12");
        cyc_op(0, 0, 0, 1, 0, '0, 0, '0, '0, "R12");
        repeat (4) idle("R13");
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule